// File: doc/BRIEF.md
# Two-Class Read-to-Clear Interrupt Status

This block gathers interrupt conditions from two origins: a bus-side class of sixteen condition lines and a DMA-side class of seven. Every condition pulse is latched into a sticky status bit. Software learns which class is pending from a summary register, then reads that class's status register. The read returns the latched conditions and clears them in the same access. A single interrupt request line is raised while either class has an enabled condition pending.

Two behaviours concern the data FIFO that sits between the bus and memory. Some bus-side conditions are fatal. When a fatal condition hits while data is being received from the bus, the block first asks for the FIFO to be drained to memory, and it holds back the bus-class interrupt until the drain is reported done. The DMA status register also carries a live FIFO-empty indication. That bit raises no interrupt and is not cleared by a read. A write-only control register issues one-cycle clear pulses to the two FIFOs.

Top module: `dual_class_irq`

## Requirements
- R1: The summary register (address 0) shows bit 0 high while any enabled bus-class condition is pending and not withheld, and bit 1 high while any enabled DMA-class condition is pending. Both bits may be high together. Bits 7:2 read 0.
- R2: Bus conditions 7:0 read at address 1 and conditions 15:8 read at address 2. A read with rd_i returns the latched bits and clears exactly that byte at the clock edge.
- R3: DMA conditions 6:0 read as bits 6:0 at address 3. A read clears them at the clock edge.
- R4: Bit 7 of address 3 equals fifo_empty_i. It never raises the interrupt and a read does not clear it.
- R5: A condition pulse in the same cycle as a read-to-clear of that bit leaves the bit set.
- R6: Enable masks sit at address 4 (bus 7:0), address 5 (bus 15:8) and address 6 bits 6:0 (DMA). All are readable and reset to all ones (address 6 bit 7 reads 0). A masked condition is still latched in status but does not count toward the summary.
- R7: Status bits, summary bits and irq_o change in the cycle after the clock edge that samples a condition pulse. irq_o is the OR of the two summary bits.
- R8: Bus conditions 0, 1, 6 and 7 are fatal. An enabled fatal pulse while rx_dir_i is high raises flush_req_o from the next cycle. flush_req_o stays high until drain_done_i is sampled, and the bus summary bit is held at 0 for that time. A new fatal pulse in the drain-done cycle keeps the request high.
- R9: A fatal condition while rx_dir_i is low raises no flush request, and the bus summary follows immediately.
- R10: A write to address 7 with bit 2 set gives a one-cycle pulse on clr_dma_fifo_o in the next cycle. Bit 1 does the same on clr_bus_fifo_o. Address 7 reads 0.
- R11: After reset, all status, summary, irq_o, flush_req_o and clear pulses are 0, and the masks are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe (clears read-to-clear status) |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| bus_evt_i | input | 16 | Bus-class condition pulses |
| dma_evt_i | input | 7 | DMA-class condition pulses |
| fifo_empty_i | input | 1 | DMA FIFO empty level |
| rx_dir_i | input | 1 | High while receiving from the bus |
| drain_done_i | input | 1 | FIFO drain to memory completed |
| flush_req_o | output | 1 | Request to drain the FIFO to memory |
| clr_dma_fifo_o | output | 1 | One-cycle DMA FIFO clear pulse |
| clr_bus_fifo_o | output | 1 | One-cycle bus FIFO clear pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take three things for granted. Condition pulses, strobes and drain-done are synchronous to clk_i. rd_i and wr_i are never high in the same cycle. addr_i is stable for the whole cycle of a strobe. The stimulus drives every input once per cycle, just after the falling edge. It picks either a read or a write or neither, never both. Condition pulses are sparse and random, and drain-done arrives at random, so flush requests both stay open for several cycles and end in the same cycle as a new fatal pulse.

// File: rtl/dci_pkg.sv
package dci_pkg;
  localparam int unsigned REG_DW = 8;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_SUM     = 3'd0,
    A_BUS_LO  = 3'd1,
    A_BUS_HI  = 3'd2,
    A_DMA     = 3'd3,
    A_MSK_LO  = 3'd4,
    A_MSK_HI  = 3'd5,
    A_MSK_DMA = 3'd6,
    A_CTRL    = 3'd7
  } reg_addr_e;

  localparam int unsigned CLR_DMA_BIT = 2;
  localparam int unsigned CLR_BUS_BIT = 1;
endpackage

// File: rtl/cond_bank.sv
module cond_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] stat_o,
  output logic         pend_o
);
  logic [W-1:0] stat_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stat_q[i] <= 1'b0;
      else if (evt_i[i]) stat_q[i] <= 1'b1;  // set beats clear
      else if (clr_i[i]) stat_q[i] <= 1'b0;
    end

    a_r5_set_wins : assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> stat_q[i]);
    a_r2_rtc_clear : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !evt_i[i]) |=> !stat_q[i]);
    a_r7_sticky : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[i] && !clr_i[i]) |=> stat_q[i]);
  end

  assign stat_o = stat_q;
  assign pend_o = |(stat_q & mask_i);
endmodule

// File: rtl/flush_hold.sv
module flush_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic drain_done_i,
  output logic hold_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= (hold_q & ~drain_done_i) | trig_i;
  end

  assign hold_o = hold_q;

  a_r8_hold_set : assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> hold_q);
  a_r8_release : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && drain_done_i && !trig_i) |=> !hold_q);
  a_r8_keep : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !drain_done_i) |=> hold_q);
endmodule

// File: rtl/dual_class_irq.sv
module dual_class_irq
  import dci_pkg::*;
#(
  parameter int unsigned DW = REG_DW,
  parameter logic [2*DW-1:0] FATAL_MASK = 16'h00C3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  input  logic [2*DW-1:0] bus_evt_i,
  input  logic [DW-2:0] dma_evt_i,
  input  logic          fifo_empty_i,
  input  logic          rx_dir_i,
  input  logic          drain_done_i,
  output logic          flush_req_o,
  output logic          clr_dma_fifo_o,
  output logic          clr_bus_fifo_o,
  output logic          irq_o
);
  localparam int unsigned BUS_W = 2 * DW;
  localparam int unsigned DMA_W = DW - 1;

  logic [BUS_W-1:0] bus_stat, bus_msk_q, bus_clr;
  logic [DMA_W-1:0] dma_stat, dma_msk_q, dma_clr;
  logic bus_pend, dma_pend, hold, fatal_rx;
  logic sum_bus, sum_dma;
  logic clr_dma_q, clr_bus_q;
  logic rd_bus_lo, rd_bus_hi, rd_dma, wr_ctrl;

  assign rd_bus_lo = rd_i && (addr_i == A_BUS_LO);
  assign rd_bus_hi = rd_i && (addr_i == A_BUS_HI);
  assign rd_dma    = rd_i && (addr_i == A_DMA);
  assign wr_ctrl   = wr_i && (addr_i == A_CTRL);

  assign bus_clr = {{DW{rd_bus_hi}}, {DW{rd_bus_lo}}};
  assign dma_clr = {DMA_W{rd_dma}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_msk_q <= '1;
      dma_msk_q <= '1;
    end else if (wr_i) begin
      case (addr_i)
        A_MSK_LO:  bus_msk_q[DW-1:0]     <= wdata_i;
        A_MSK_HI:  bus_msk_q[BUS_W-1:DW] <= wdata_i;
        A_MSK_DMA: dma_msk_q             <= wdata_i[DMA_W-1:0];
        default: ;
      endcase
    end
  end

  cond_bank #(.W(BUS_W)) u_bus_bank (
    .clk_i (clk_i), .rst_ni (rst_ni), .evt_i (bus_evt_i), .clr_i (bus_clr),
    .mask_i (bus_msk_q), .stat_o (bus_stat), .pend_o (bus_pend)
  );

  cond_bank #(.W(DMA_W)) u_dma_bank (
    .clk_i (clk_i), .rst_ni (rst_ni), .evt_i (dma_evt_i), .clr_i (dma_clr),
    .mask_i (dma_msk_q), .stat_o (dma_stat), .pend_o (dma_pend)
  );

  assign fatal_rx = rx_dir_i && |(bus_evt_i & FATAL_MASK & bus_msk_q);

  flush_hold u_hold (
    .clk_i (clk_i), .rst_ni (rst_ni), .trig_i (fatal_rx),
    .drain_done_i (drain_done_i), .hold_o (hold)
  );

  assign sum_bus     = bus_pend && !hold;
  assign sum_dma     = dma_pend;
  assign irq_o       = sum_bus || sum_dma;
  assign flush_req_o = hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_dma_q <= 1'b0;
      clr_bus_q <= 1'b0;
    end else begin
      clr_dma_q <= wr_ctrl && wdata_i[CLR_DMA_BIT];
      clr_bus_q <= wr_ctrl && wdata_i[CLR_BUS_BIT];
    end
  end
  assign clr_dma_fifo_o = clr_dma_q;
  assign clr_bus_fifo_o = clr_bus_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_SUM:     rdata_o[1:0] = {sum_dma, sum_bus};
      A_BUS_LO:  rdata_o = bus_stat[DW-1:0];
      A_BUS_HI:  rdata_o = bus_stat[BUS_W-1:DW];
      A_DMA:     rdata_o = {fifo_empty_i, dma_stat};
      A_MSK_LO:  rdata_o = bus_msk_q[DW-1:0];
      A_MSK_HI:  rdata_o = bus_msk_q[BUS_W-1:DW];
      A_MSK_DMA: rdata_o = {1'b0, dma_msk_q};
      default:   rdata_o = '0;
    endcase
  end

  a_r10_clr_dma : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && wdata_i[CLR_DMA_BIT]) |=> clr_dma_fifo_o);
  a_r10_clr_quiet : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> (!clr_dma_fifo_o && !clr_bus_fifo_o));
  a_r9_tx_no_flush : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_dir_i && !flush_req_o) |=> !flush_req_o);
  a_r4_empty_quiet : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_stat == '0 && !bus_pend) |-> !irq_o);
  a_r8_withhold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_req_o && !sum_dma) |-> !irq_o);
endmodule

// File: tb/dual_class_irq_test.sv
`timescale 1ns/1ps
module dual_class_irq_test;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic wr_i = 0, rd_i = 0, fifo_empty_i = 0, rx_dir_i = 0, drain_done_i = 0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic [15:0] bus_evt_i = '0;
  logic [6:0] dma_evt_i = '0;
  logic flush_req_o, clr_dma_fifo_o, clr_bus_fifo_o, irq_o;

  localparam logic [15:0] FATAL = 16'h00C3;

  dual_class_irq uut (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_bst = '0, m_bmsk = '1;
  logic [6:0] m_dst = '0, m_dmsk = '1;
  logic m_hold = 0, m_cdma = 0, m_cbus = 0;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic sum_b(); return |(m_bst & m_bmsk) && !m_hold; endfunction
  function automatic logic sum_d(); return |(m_dst & m_dmsk); endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a, input logic fe);
    case (a)
      3'd0: return {6'd0, sum_d(), sum_b()};
      3'd1: return m_bst[7:0];
      3'd2: return m_bst[15:8];
      3'd3: return {fe, m_dst};
      3'd4: return m_bmsk[7:0];
      3'd5: return m_bmsk[15:8];
      3'd6: return {1'b0, m_dmsk};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R1 summary read";
      3'd1, 3'd2: return "R2 bus status read";
      3'd3: return "R3/R4 dma status read";
      3'd7: return "R10 ctrl reads zero";
      default: return "R6 mask read";
    endcase
  endfunction

  task automatic step(input logic rd, input logic wr, input logic [2:0] a,
                      input logic [7:0] wd, input logic [15:0] be, input logic [6:0] de,
                      input logic rx, input logic dd, input logic fe);
    logic fr;
    rd_i = rd; wr_i = wr; addr_i = a; wdata_i = wd; bus_evt_i = be;
    dma_evt_i = de; rx_dir_i = rx; drain_done_i = dd; fifo_empty_i = fe;
    #1;
    chk(irq_o, sum_b() || sum_d(), "R7 irq");
    chk(flush_req_o, m_hold, "R8/R9 flush_req");
    chk(clr_dma_fifo_o, m_cdma, "R10 clr_dma pulse");
    chk(clr_bus_fifo_o, m_cbus, "R10 clr_bus pulse");
    if (rd) chk(rdata_o, exp_rd(a, fe), rd_tag(a));
    @(posedge clk_i);
    fr = rx && |(be & FATAL & m_bmsk);
    m_bst = (m_bst & ~{{8{rd && a == 3'd2}}, {8{rd && a == 3'd1}}}) | be;
    m_dst = (m_dst & ~{7{rd && a == 3'd3}}) | de;
    m_hold = (m_hold && !dd) || fr;
    m_cdma = wr && a == 3'd7 && wd[2];
    m_cbus = wr && a == 3'd7 && wd[1];
    if (wr && a == 3'd4) m_bmsk[7:0] = wd;
    if (wr && a == 3'd5) m_bmsk[15:8] = wd;
    if (wr && a == 3'd6) m_dmsk = wd[6:0];
    @(negedge clk_i);
  endtask

  task automatic idle(); step(0,0,0,0,0,0,0,0,0); endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd77));
    #7 rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    step(1,0,3'd0,0,0,0,0,0,0);
    step(1,0,3'd4,0,0,0,0,0,0);
    step(1,0,3'd6,0,0,0,0,0,0);
    // R4: empty flag reads back, no irq, survives read
    step(1,0,3'd3,0,0,0,0,0,1);
    step(1,0,3'd3,0,0,0,0,0,1);
    // R9: fatal bit 0 while sending
    step(0,0,0,0,16'h0001,0,0,0,0);
    step(1,0,3'd0,0,0,0,0,0,0);
    step(1,0,3'd1,0,0,0,0,0,0);
    step(1,0,3'd1,0,0,0,0,0,0);
    // R8: fatal bit 7 while receiving, drain later
    step(0,0,0,0,16'h0080,0,1,0,0);
    idle(); idle();
    step(1,0,3'd0,0,0,0,0,0,0);
    step(0,0,0,0,0,0,1,1,0);
    step(1,0,3'd0,0,0,0,0,0,0);
    // R8: new fatal in the drain-done cycle
    step(0,0,0,0,16'h0002,0,1,0,0);
    step(0,0,0,0,16'h0040,0,1,1,0);
    idle();
    step(0,0,0,0,0,0,0,1,0);
    step(1,0,3'd1,0,0,0,0,0,0);
    // R5: set and clear in the same cycle
    step(1,0,3'd2,0,16'h0400,7'h04,0,0,0);
    step(1,0,3'd2,0,0,0,0,0,0);
    step(1,0,3'd3,0,0,7'h04,0,0,0);
    step(1,0,3'd3,0,0,0,0,0,0);
    // R6: mask bus byte 0, condition latched but no irq
    step(0,1,3'd4,8'h00,0,0,0,0,0);
    step(0,0,0,0,16'h0004,0,0,0,0);
    step(1,0,3'd1,0,0,0,0,0,0);
    step(0,1,3'd4,8'hFF,0,0,0,0,0);
    // R1: both classes at once
    step(0,0,0,0,16'h0100,7'h01,0,0,0);
    step(1,0,3'd0,0,0,0,0,0,0);
    step(1,0,3'd2,0,0,0,0,0,0);
    step(1,0,3'd3,0,0,0,0,0,0);
    // R10 clear pulses
    step(0,1,3'd7,8'h04,0,0,0,0,0);
    step(0,1,3'd7,8'h02,0,0,0,0,0);
    step(1,0,3'd7,0,0,0,0,0,0);
    idle();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int unsigned op = $urandom_range(0, 9);
      logic [2:0] a = 3'($urandom_range(0, 7));
      logic [7:0] wd = 8'($urandom);
      if (a == 3'd6 || a == 3'd4 || a == 3'd5) wd = wd | 8'($urandom);
      step(op < 5, op == 5 || op == 6, a, wd,
           16'($urandom & $urandom & $urandom & $urandom),
           7'($urandom & $urandom & $urandom),
           1'($urandom), $urandom_range(0, 7) == 0, 1'($urandom));
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule